// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a bus-mapped watchdog. Once software turns it on, a fixed divide-by-32 prescaler feeds a timeout counter. The counter's terminal value is two raised to a postscale exponent, and that exponent is fixed by strap pins at reset. If software lets the counter reach the terminal value, the block issues a one-cycle reset request and starts counting again from zero. Software keeps the system alive by writing a 16-bit restart key into the upper half-word of the control register. Other values, and writes of other sizes, leave the count unchanged.

Each timeout also sets a sticky flag in a reset-status register. That register sits in its own address window and is reset only by the power-on reset input. The flag therefore survives the system reset that the watchdog itself triggers, and boot software can see why the chip restarted. Every register can be written directly, and also through a clear alias and a set alias, which apply a bit mask atomically.

Read data is combinational: it follows the word address on the bus. Writes take effect at the clock edge where select and write are both high.

Top module: `kwdt_top`

## Requirements
- R1: After `rst_n` is released, the enable bit (control bit 15) is 0, `wdt_rst_req` is low, and the control word shows the strap fields: postscale exponent in bits 12:8, clock select in bits 7:6, window flag in bit 0. All other bits read 0.
- R2: The strap fields cannot be changed over the bus. A write of any data, to any control alias, leaves them unchanged.
- R3: The enable bit changes only on a write with byte strobe 1 set. A write to 0x00 loads it from data bit 15. A write to 0x04 clears it when data bit 15 is 1. A write to 0x08 sets it when data bit 15 is 1.
- R4: Counting starts from zero when the watchdog is enabled. Once it has been enabled for 32·2^P cycles with no restart (P is the postscale exponent), `wdt_rst_req` goes high for exactly one cycle and counting begins again from zero.
- R5: A write to 0x00 with byte strobes 4'b1100 and data bits 31:16 equal to 16'h5743 restarts the count from zero. A different key value, or the same key written with any other strobe pattern (including a full 32-bit write), does not restart the count.
- R6: A valid restart key that arrives on the same edge as the terminal count suppresses that timeout.
- R7: While the watchdog is disabled, the prescaler and counter stay at zero and `wdt_rst_req` stays low.
- R8: A timeout sets status bit 4 (register 0x10). Reset by `rst_n` does not clear it. It clears only on `por_n` or on a write to 0x14 with byte strobe 0 set and data bit 4 set. A write to 0x18 with the same strobe and data sets it. A timeout on the same edge as a clear wins.
- R9: Any write made in the cycle directly after the enable bit goes from 1 to 0 is ignored.
- R10: Addresses 0x0C and 0x1C read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset (async). Also loads the straps |
| por_n | input | 1 | Active-low power-on reset for the status register |
| strap_ps | input | 5 | Postscale exponent strap |
| strap_cs | input | 2 | Clock-select strap (readback only) |
| strap_win | input | 1 | Window-mode strap (readback only) |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_be | input | 4 | Byte strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
Wrong internal state shows up at the ports in one of two ways. A bad prescaler or counter value moves the edge of `wdt_rst_req` away from the exact 32·2^P-cycle mark, or produces it after a restart key that should have suppressed it. A bad enable or sticky flag shows on `bus_rdata` in the same cycle as the offending edge, because reads are combinational. The bench drives the design with a reference model that counts elapsed enabled cycles, not prescaler and counter fields, and compares both outputs every clock. Most counter faults are therefore caught within one timeout period, and register faults within one cycle.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned EN_BIT   = 15;
    localparam int unsigned WIN_BIT  = 0;
    localparam int unsigned CS_LSB   = 6;
    localparam int unsigned PS_LSB   = 8;
    localparam int unsigned STAT_BIT = 4;

    // word offsets inside each 16-byte window (addr[3:2])
    typedef enum logic [1:0] {
        OFS_BASE = 2'd0,
        OFS_CLR  = 2'd1,
        OFS_SET  = 2'd2,
        OFS_NONE = 2'd3
    } ofs_e;

    // decoded write actions for one cycle
    typedef struct packed {
        logic en_wr;
        logic en_val;
        logic key;
        logic st_set;
        logic st_clr;
    } wr_act_t;

endpackage

// File: rtl/kwdt_bus_dec.sv
module kwdt_bus_dec
    import kwdt_pkg::*;
#(
    parameter logic [15:0] KEY = 16'h5743
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    input  logic              blk,
    output wr_act_t           act
);

    logic   wv;
    logic   win_sts;
    ofs_e   ofs;
    logic   unused_bits;

    assign wv      = sel && wr && !blk;
    assign win_sts = addr[4];
    assign ofs     = ofs_e'(addr[3:2]);
    assign unused_bits = ^{addr[1:0], wdata[14:5], wdata[3:0]};

    always_comb begin
        act = '0;
        if (wv && !win_sts) begin
            unique case (ofs)
                OFS_BASE: begin
                    if (be[1]) begin
                        act.en_wr  = 1'b1;
                        act.en_val = wdata[EN_BIT];
                    end
                    act.key = (be == 4'b1100) && (wdata[31:16] == KEY);
                end
                OFS_CLR: begin
                    act.en_wr  = be[1] && wdata[EN_BIT];
                    act.en_val = 1'b0;
                end
                OFS_SET: begin
                    act.en_wr  = be[1] && wdata[EN_BIT];
                    act.en_val = 1'b1;
                end
                default: ;
            endcase
        end
        if (wv && win_sts && be[0] && wdata[STAT_BIT]) begin
            act.st_clr = (ofs == OFS_CLR);
            act.st_set = (ofs == OFS_SET);
        end
    end

endmodule

// File: rtl/kwdt_timebase.sv
module kwdt_timebase #(
    parameter int unsigned PRE_LOG2 = 5,
    parameter int unsigned PS_W     = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] ps,
    output logic            timeout
);

    localparam int unsigned CNT_W = 2 ** PS_W;

    typedef struct packed {
        logic [PRE_LOG2-1:0] pre;
        logic [CNT_W-1:0]    cnt;
    } tb_t;

    tb_t              tb_d, tb_q;
    logic [CNT_W-1:0] term_m1;
    logic             pre_wrap;

    assign term_m1  = (CNT_W'(1) << ps) - CNT_W'(1);
    assign pre_wrap = (tb_q.pre == {PRE_LOG2{1'b1}});
    assign timeout  = run && !restart && pre_wrap && (tb_q.cnt == term_m1);

    always_comb begin
        tb_d = tb_q;
        if (!run || restart || timeout) begin
            tb_d = '0;
        end else begin
            tb_d.pre = tb_q.pre + 1'b1;
            if (pre_wrap) begin
                tb_d.cnt = tb_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int unsigned PS_W     = 5,
    parameter int unsigned CS_W     = 2,
    parameter int unsigned PRE_LOG2 = 5,
    parameter logic [15:0] KEY      = 16'h5743
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [PS_W-1:0]   strap_ps,
    input  logic [CS_W-1:0]   strap_cs,
    input  logic              strap_win,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_rst_req
);

    typedef struct packed {
        logic            en;
        logic            blk;
        logic            req;
        logic [PS_W-1:0] ps;
        logic [CS_W-1:0] cs;
        logic            win;
    } ctl_t;

    ctl_t    st_d, st_q;
    logic    sts_d, sts_q;
    wr_act_t act;
    logic    timeout;

    // names visible to the bound checker
    logic            en_w;
    logic            sts_w;
    logic [PS_W-1:0] ps_w;

    kwdt_bus_dec #(.KEY(KEY)) u_dec (
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .be    (bus_be),
        .wdata (bus_wdata),
        .blk   (st_q.blk),
        .act   (act)
    );

    kwdt_timebase #(.PRE_LOG2(PRE_LOG2), .PS_W(PS_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.en),
        .restart (act.key),
        .ps      (st_q.ps),
        .timeout (timeout)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = timeout;
        if (act.en_wr) begin
            st_d.en = act.en_val;
        end
        st_d.blk = st_q.en && !st_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, blk: 1'b0, req: 1'b0,
                      ps: strap_ps, cs: strap_cs, win: strap_win};
        end else begin
            st_q <= st_d;
        end
    end

    // sticky status lives on the power-on reset only
    always_comb begin
        sts_d = sts_q;
        if (act.st_clr) sts_d = 1'b0;
        if (act.st_set) sts_d = 1'b1;
        if (timeout)    sts_d = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sts_q <= 1'b0;
        end else begin
            sts_q <= sts_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[3:2] != OFS_NONE) begin
            if (bus_addr[4]) begin
                bus_rdata[STAT_BIT] = sts_q;
            end else begin
                bus_rdata[EN_BIT]            = st_q.en;
                bus_rdata[PS_LSB +: PS_W]    = st_q.ps;
                bus_rdata[CS_LSB +: CS_W]    = st_q.cs;
                bus_rdata[WIN_BIT]           = st_q.win;
            end
        end
    end

    assign wdt_rst_req = st_q.req;
    assign en_w        = st_q.en;
    assign sts_w       = sts_q;
    assign ps_w        = st_q.ps;

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter int unsigned PS_W = 5,
    parameter logic [15:0] KEY  = 16'h5743
) (
    input logic            clk,
    input logic            rst_n,
    input logic            por_n,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic [4:0]      bus_addr,
    input logic [3:0]      bus_be,
    input logic [15:0]     key_half,
    input logic            stat_data,
    input logic            wdt_rst_req,
    input logic            en_w,
    input logic            sts_w,
    input logic [PS_W-1:0] ps_w
);

    logic key_wr;
    logic clr_wr;

    assign key_wr = bus_sel && bus_wr && (bus_addr[4:2] == 3'd0)
                    && (bus_be == 4'b1100) && (key_half == KEY);
    assign clr_wr = bus_sel && bus_wr && (bus_addr[4:2] == 3'd5)
                    && bus_be[0] && stat_data;

    // R4: the request lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req);

    // R7: no request while disabled
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_w |=> !wdt_rst_req);

    // R6: a key at the terminal edge wins
    a_r6_key_beats_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w && key_wr) |=> !wdt_rst_req);

    // R8: a request is always mirrored in the sticky flag
    a_r8_flag_follows_req: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        wdt_rst_req |-> sts_w);

    // R8: the flag holds unless a clear is written
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (sts_w && !clr_wr) |=> sts_w);

    // R2: the strap field never moves outside reset
    a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        en_w || !en_w |=> $stable(ps_w));

endmodule

bind kwdt_top kwdt_checker #(.PS_W(PS_W), .KEY(KEY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_n       (por_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be),
    .key_half    (bus_wdata[31:16]),
    .stat_data   (bus_wdata[4]),
    .wdt_rst_req (wdt_rst_req),
    .en_w        (en_w),
    .sts_w       (sts_w),
    .ps_w        (ps_w)
);

// File: tb/kwdt_top_test.sv
module kwdt_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic [4:0]  strap_ps = 5'd1;
    logic [1:0]  strap_cs = 2'd2;
    logic        strap_win = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h00;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req;

    always #4 clk = ~clk;   // 125 MHz

    kwdt_top uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .strap_ps(strap_ps), .strap_cs(strap_cs), .strap_win(strap_win),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_req(wdt_rst_req)
    );

    // reference model state
    bit        m_en, m_blk, m_req, m_stat, m_win;
    bit [4:0]  m_ps;
    bit [1:0]  m_cs;
    longint    m_el;
    int        vecs = 0;
    int        fails = 0;
    int        cyc = 0;
    bit        done = 1'b0;
    string     cur_req = "R1";

    function automatic logic [31:0] exp_rdata(input logic [4:0] a);
        logic [31:0] v;
        v = '0;
        if (a[3:2] != 2'd3) begin
            if (a[4]) v[4] = m_stat;
            else begin
                v[15]   = m_en;
                v[12:8] = m_ps;
                v[7:6]  = m_cs;
                v[0]    = m_win;
            end
        end
        return v;
    endfunction

    always @(posedge clk) begin
        bit wv, key, to, nen;
        longint lim;
        if (!rst_n) begin
            m_en = 0; m_blk = 0; m_req = 0; m_el = 0;
            m_ps = strap_ps; m_cs = strap_cs; m_win = strap_win;
            if (!por_n) m_stat = 0;
        end else begin
            wv  = bus_sel && bus_wr && !m_blk;
            lim = longint'(32) << m_ps;
            key = wv && bus_addr == 5'h00 && bus_be == 4'b1100
                  && bus_wdata[31:16] == 16'h5743;
            to  = 0;
            if (m_en) begin
                if (key) m_el = 0;
                else if (m_el + 1 == lim) begin to = 1; m_el = 0; end
                else m_el = m_el + 1;
            end
            nen = m_en;
            if (wv && bus_be[1]) begin
                if (bus_addr == 5'h00) nen = bus_wdata[15];
                if (bus_addr == 5'h04 && bus_wdata[15]) nen = 0;
                if (bus_addr == 5'h08 && bus_wdata[15]) nen = 1;
            end
            if (!nen) m_el = 0;
            m_blk = m_en && !nen;
            m_en  = nen;
            m_req = to;
            if (wv && bus_be[0] && bus_wdata[4]) begin
                if (bus_addr == 5'h14) m_stat = 0;
                if (bus_addr == 5'h18) m_stat = 1;
            end
            if (to) m_stat = 1;
            if (!por_n) m_stat = 0;
        end
        #2;
        if (!done) begin
            vecs++;
            if (wdt_rst_req !== m_req) begin
                fails++;
                $display("FAIL %s wdt_rst_req got %0b exp %0b (cycle %0d)",
                         cur_req, wdt_rst_req, m_req, cyc);
            end
            vecs++;
            if (bus_rdata !== exp_rdata(bus_addr)) begin
                fails++;
                $display("FAIL %s bus_rdata@%h got %h exp %h (cycle %0d)",
                         cur_req, bus_addr, bus_rdata, exp_rdata(bus_addr), cyc);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            fails++;
            $display("FAIL watchdog expired in %s", cur_req);
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0; bus_wdata = 32'h0;
    endtask

    initial begin
        idle(3);
        por_n = 1'b1; rst_n = 1'b1;
        // R1: reset view of control word
        cur_req = "R1";
        idle(3);
        // R2: try to overwrite strap fields with enable kept at 0
        cur_req = "R2";
        wr(5'h00, 4'b1111, 32'hFFFF_7FFF);
        wr(5'h08, 4'b1111, 32'h0000_1FC1);
        wr(5'h04, 4'b1111, 32'h0000_1FC1);
        idle(2);
        // R7: disabled for a long stretch, no request
        cur_req = "R7";
        idle(100);
        // R3: enable through the set alias
        cur_req = "R3";
        wr(5'h08, 4'b0010, 32'h0000_8000);
        idle(2);
        // R5: good keys inside the 64-cycle period keep it quiet
        cur_req = "R5";
        for (int i = 0; i < 5; i++) begin
            idle(40);
            wr(5'h00, 4'b1100, 32'h5743_0000);
        end
        idle(20);
        wr(5'h00, 4'b1100, 32'h5742_0000);   // wrong key
        wr(5'h00, 4'b1111, 32'h5743_8000);   // full word: no restart
        // R4: free-running timeouts
        cur_req = "R4";
        idle(200);
        // R8: status readback and clear alias
        cur_req = "R8";
        bus_addr = 5'h10;
        idle(3);
        wr(5'h14, 4'b0001, 32'h0000_0010);
        bus_addr = 5'h10;
        idle(70);
        // R9: write in the cycle after disable is dropped
        cur_req = "R9";
        wr(5'h04, 4'b0010, 32'h0000_8000);
        wr(5'h08, 4'b0010, 32'h0000_8000);
        bus_addr = 5'h00;
        idle(3);
        wr(5'h08, 4'b0010, 32'h0000_8000);
        idle(2);
        wr(5'h00, 4'b0010, 32'h0000_0000);
        wr(5'h18, 4'b0001, 32'h0000_0010);
        bus_addr = 5'h10;
        idle(3);
        // R8: flag survives the system reset, straps reloaded
        cur_req = "R8";
        wr(5'h18, 4'b0001, 32'h0000_0010);
        strap_ps = 5'd0;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        bus_addr = 5'h10;
        idle(2);
        // R6: key landing on the terminal edge (period 32)
        cur_req = "R6";
        wr(5'h00, 4'b0010, 32'h0000_8000);
        idle(31);
        wr(5'h00, 4'b1100, 32'h5743_0000);
        idle(70);
        // R8: clear racing a timeout is checked by the model every cycle
        cur_req = "R8";
        wr(5'h14, 4'b0001, 32'h0000_0010);
        bus_addr = 5'h10;
        idle(40);
        // R10: unused words
        cur_req = "R10";
        bus_addr = 5'h0C;
        idle(2);
        bus_addr = 5'h1C;
        idle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule